// File: doc/BRIEF.md
# Base-Plus-Delta Compressed Sample Memory

This block is the sample store of a streaming biosignal front end. Fixed-width two's complement samples arrive in order on a valid/ready stream and are collected in groups of adjacent samples. When a group shows value locality, it is packed as its first sample at full width followed by short signed differences of the remaining samples from that first one. The packed word goes into a compact compressed array. A group whose differences do not all fit the short field is written unpacked into a smaller backup array instead. A two-bit tag per group records which array holds it, or that the group is absent.

A random-access read port takes a logical sample index and returns the rebuilt sample a fixed two cycles later. The tag is looked up in the first read stage. The second stage enables only the array that holds the group, so the other array stays idle. When a group is packed, each fitting difference is kept exactly, so storage is lossless. A static mode input selects the difference field width: half or a quarter of the sample width. Counters of packed and backup groups let a test compare storage use against a model.

Top module: `bpd_sample_store`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1, `overflow` is 0, both group counters are 0, and a read of any index returns 0.
- R2: With `quarter_mode` = 0 (half width), a group whose second to fourth samples each differ from its first by a value in [-128, 127] is packed, and every sample reads back exactly. Sample `p` (0..3) of group `g` (in arrival order from reset) is read at `rd_index` = 4*g + p.
- R3: With `quarter_mode` = 1 (quarter width), a group is packed only when every difference lies in [-8, 7]. A difference of 8 makes the group a backup group, and its samples still read back exactly.
- R4: A group with any difference outside the selected range is stored at full width in the backup array and reads back exactly, including the sample extremes -32768 and 32767.
- R5: `rd_valid` is high in exactly the cycles two cycles after a cycle with `rd_req` high, and `rd_data` then holds the requested sample.
- R6: A group becomes readable one cycle after its fourth sample is accepted. A read requested in the cycle right after that acceptance, or a read of a partially received group, returns 0.
- R7: Each completed group increments exactly one of `hit_count` (packed) or `miss_count` (backup or dropped).
- R8: Once the backup array holds 4 groups, later backup groups are dropped. `overflow` rises and stays high until reset. A dropped group reads as 0, and packed groups arriving after it are still stored.
- R9: After 16 groups have been accepted, `in_ready` is 0, further `in_valid` pulses are not accepted, and both counters stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| quarter_mode | input | 1 | Static field width select: 0 half, 1 quarter |
| in_valid | input | 1 | Incoming sample valid |
| in_data | input | 16 | Incoming sample, two's complement |
| in_ready | output | 1 | Memory can accept a sample |
| rd_req | input | 1 | Read request strobe |
| rd_index | input | 6 | Logical sample index, 4*group + position |
| rd_valid | output | 1 | Read result valid, two cycles after request |
| rd_data | output | 16 | Rebuilt sample |
| overflow | output | 1 | Sticky: a backup group was dropped |
| hit_count | output | 5 | Groups stored packed |
| miss_count | output | 5 | Groups that missed locality |

## Verification
Packing is tried with groups whose differences sit exactly on the edges of the field range (127 and -128 in half mode, 7 and -8 in quarter mode) and with groups one step beyond those edges (128, 8). This separates an off-by-one range test from a correct one, and a half/quarter mix-up from the right mode. Full-scale extremes in a backup group show whether the difference is computed with enough headroom. A run of backup groups past the backup capacity, followed by packed groups, separates dropping from corrupting. Reads placed on the commit cycle and on half-filled groups pin down when a group becomes visible.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
   // Storage state of one logical group
   typedef enum logic [1:0] {
      GT_EMPTY = 2'd0,   // not yet committed
      GT_HIT   = 2'd1,   // packed in compressed array
      GT_MISS  = 2'd2,   // full width in backup array
      GT_LOST  = 2'd3    // missed while backup array was full
   } grp_tag_e;
endpackage

// File: rtl/bpd_delta_fit.sv
module bpd_delta_fit #(
   parameter int SAMPLE_W = 16,
   parameter int GROUP_N  = 4,
   localparam int DH      = SAMPLE_W / 2,
   localparam int DQ      = SAMPLE_W / 4
) (
   input  logic [GROUP_N*SAMPLE_W-1:0] grp_flat,
   input  logic                        quarter,
   output logic                        hit,
   output logic [(GROUP_N-1)*DH-1:0]   deltas
);
   localparam int DW = SAMPLE_W + 1;

   logic [GROUP_N-2:0] fit_h;
   logic [GROUP_N-2:0] fit_q;
   logic [SAMPLE_W-1:0] s0;

   assign s0 = grp_flat[SAMPLE_W-1:0];

   for (genvar k = 1; k < GROUP_N; k++) begin : g_lane
      logic [SAMPLE_W-1:0] sk;
      logic [DW-1:0]       diff;
      assign sk   = grp_flat[k*SAMPLE_W +: SAMPLE_W];
      // one extra bit so full-scale differences do not wrap
      assign diff = {sk[SAMPLE_W-1], sk} - {s0[SAMPLE_W-1], s0};
      assign fit_h[k-1] = (&diff[DW-1:DH-1]) | ~(|diff[DW-1:DH-1]);
      assign fit_q[k-1] = (&diff[DW-1:DQ-1]) | ~(|diff[DW-1:DQ-1]);
      assign deltas[(k-1)*DH +: DH] = diff[DH-1:0];
   end

   assign hit = quarter ? (&fit_q) : (&fit_h);
endmodule

// File: rtl/bpd_packer.sv
module bpd_packer #(
   parameter int SAMPLE_W = 16,
   parameter int GROUP_N  = 4,
   parameter int GROUPS   = 16,
   localparam int LANE_W  = $clog2(GROUP_N),
   localparam int GRP_W   = $clog2(GROUPS),
   localparam int FILL_W  = $clog2(GROUPS + 1)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        in_valid,
   input  logic [SAMPLE_W-1:0]         in_data,
   output logic                        in_ready,
   output logic                        stg_valid,
   output logic [GRP_W-1:0]            stg_group,
   output logic [GROUP_N*SAMPLE_W-1:0] stg_flat
);
   logic [LANE_W-1:0]               lane_q;
   logic [FILL_W-1:0]               fill_q;
   logic [(GROUP_N-1)*SAMPLE_W-1:0] hold_q;
   logic                            accept;
   logic                            last;

   assign in_ready = (fill_q != FILL_W'(GROUPS));
   assign accept   = in_valid & in_ready;
   assign last     = (lane_q == LANE_W'(GROUP_N - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         lane_q    <= '0;
         fill_q    <= '0;
         stg_valid <= 1'b0;
      end else begin
         stg_valid <= accept & last;
         if (accept) begin
            if (last) begin
               lane_q <= '0;
               fill_q <= fill_q + FILL_W'(1);
            end else begin
               lane_q <= lane_q + LANE_W'(1);
            end
         end
      end
   end

   // data path, no reset needed
   always_ff @(posedge clk) begin
      if (accept) begin
         if (last) begin
            stg_flat  <= {in_data, hold_q};
            stg_group <= fill_q[GRP_W-1:0];
         end else begin
            for (int k = 0; k < GROUP_N - 1; k++)
               if (lane_q == LANE_W'(k))
                  hold_q[k*SAMPLE_W +: SAMPLE_W] <= in_data;
         end
      end
   end
endmodule

// File: rtl/bpd_lane_decode.sv
module bpd_lane_decode #(
   parameter int SAMPLE_W = 16,
   parameter int GROUP_N  = 4,
   localparam int DH      = SAMPLE_W / 2,
   localparam int DQ      = SAMPLE_W / 4,
   localparam int CW      = SAMPLE_W + (GROUP_N - 1) * DH,
   localparam int LANE_W  = $clog2(GROUP_N)
) (
   input  logic [CW-1:0]       entry,
   input  logic [LANE_W-1:0]   lane,
   input  logic                quarter,
   output logic [SAMPLE_W-1:0] value
);
   function automatic logic [SAMPLE_W-1:0] widen(input logic [DH-1:0] f,
                                                 input logic q);
      if (q) return {{(SAMPLE_W-DQ){f[DQ-1]}}, f[DQ-1:0]};
      return {{(SAMPLE_W-DH){f[DH-1]}}, f};
   endfunction

   logic [SAMPLE_W-1:0] base;
   assign base = entry[SAMPLE_W-1:0];

   always_comb begin
      value = base;
      for (int k = 1; k < GROUP_N; k++)
         if (lane == LANE_W'(k))
            value = base + widen(entry[SAMPLE_W + (k-1)*DH +: DH], quarter);
   end
endmodule

// File: rtl/bpd_sample_store.sv
module bpd_sample_store
   import bpd_pkg::*;
#(
   parameter int SAMPLE_W     = 16,
   parameter int GROUP_N      = 4,
   parameter int GROUPS       = 16,
   parameter int BACKUP_SLOTS = 4,
   localparam int LANE_W      = $clog2(GROUP_N),
   localparam int GRP_W       = $clog2(GROUPS),
   localparam int IDX_W       = LANE_W + GRP_W,
   localparam int CNT_W       = $clog2(GROUPS + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                quarter_mode,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_data,
   output logic                in_ready,
   input  logic                rd_req,
   input  logic [IDX_W-1:0]    rd_index,
   output logic                rd_valid,
   output logic [SAMPLE_W-1:0] rd_data,
   output logic                overflow,
   output logic [CNT_W-1:0]    hit_count,
   output logic [CNT_W-1:0]    miss_count
);
   localparam int DH     = SAMPLE_W / 2;
   localparam int CW     = SAMPLE_W + (GROUP_N - 1) * DH;
   localparam int RW     = GROUP_N * SAMPLE_W;
   localparam int SLOT_W = (BACKUP_SLOTS > 1) ? $clog2(BACKUP_SLOTS) : 1;
   localparam int PTR_W  = $clog2(BACKUP_SLOTS + 1);

   // elaboration-time parameter checks
   initial begin
      assert (SAMPLE_W >= 8 && SAMPLE_W % 4 == 0)
         else $error("SAMPLE_W must be a multiple of 4, at least 8");
      assert (GROUP_N >= 2 && (GROUP_N & (GROUP_N - 1)) == 0)
         else $error("GROUP_N must be a power of two, at least 2");
      assert (GROUPS >= 2 && (GROUPS & (GROUPS - 1)) == 0)
         else $error("GROUPS must be a power of two, at least 2");
      assert (BACKUP_SLOTS >= 1 && BACKUP_SLOTS <= GROUPS)
         else $error("BACKUP_SLOTS must lie in 1..GROUPS");
   end

   // ---------------- write side ----------------
   logic                  stg_valid;
   logic [GRP_W-1:0]      stg_group;
   logic [RW-1:0]         stg_flat;
   logic                  fit_hit;
   logic [CW-SAMPLE_W-1:0] fit_deltas;

   bpd_packer #(.SAMPLE_W(SAMPLE_W), .GROUP_N(GROUP_N), .GROUPS(GROUPS)) u_pack (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .stg_valid(stg_valid), .stg_group(stg_group),
      .stg_flat(stg_flat)
   );

   bpd_delta_fit #(.SAMPLE_W(SAMPLE_W), .GROUP_N(GROUP_N)) u_fit (
      .grp_flat(stg_flat), .quarter(quarter_mode), .hit(fit_hit),
      .deltas(fit_deltas)
   );

   logic [CW-1:0]     cmp_mem [GROUPS];
   logic [RW-1:0]     bak_mem [BACKUP_SLOTS];
   logic [SLOT_W-1:0] slot_q  [GROUPS];
   grp_tag_e          tag_q   [GROUPS];
   logic [PTR_W-1:0]  bak_ptr_q;
   logic              bak_free;

   assign bak_free = (bak_ptr_q != PTR_W'(BACKUP_SLOTS));

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int g = 0; g < GROUPS; g++) tag_q[g] <= GT_EMPTY;
         bak_ptr_q  <= '0;
         overflow   <= 1'b0;
         hit_count  <= '0;
         miss_count <= '0;
      end else if (stg_valid) begin
         if (fit_hit) begin
            tag_q[stg_group] <= GT_HIT;
            hit_count        <= hit_count + CNT_W'(1);
         end else begin
            miss_count <= miss_count + CNT_W'(1);
            if (bak_free) begin
               tag_q[stg_group] <= GT_MISS;
               bak_ptr_q        <= bak_ptr_q + PTR_W'(1);
            end else begin
               tag_q[stg_group] <= GT_LOST;
               overflow         <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (stg_valid && fit_hit)
         cmp_mem[stg_group] <= {fit_deltas, stg_flat[SAMPLE_W-1:0]};
      if (stg_valid && !fit_hit && bak_free) begin
         bak_mem[bak_ptr_q[SLOT_W-1:0]] <= stg_flat;
         slot_q[stg_group]              <= bak_ptr_q[SLOT_W-1:0];
      end
   end

   // ---------------- read side ----------------
   logic              r1_valid;
   grp_tag_e          r1_tag;
   logic [SLOT_W-1:0] r1_slot;
   logic [GRP_W-1:0]  r1_grp;
   logic [LANE_W-1:0] r1_lane;

   always_ff @(posedge clk) begin
      if (rst) r1_valid <= 1'b0;
      else     r1_valid <= rd_req;
   end

   always_ff @(posedge clk) begin
      if (rd_req) begin
         r1_tag  <= tag_q[rd_index[IDX_W-1:LANE_W]];
         r1_slot <= slot_q[rd_index[IDX_W-1:LANE_W]];
         r1_grp  <= rd_index[IDX_W-1:LANE_W];
         r1_lane <= rd_index[LANE_W-1:0];
      end
   end

   // only the section holding the group is enabled
   logic                cmp_en, bak_en;
   logic [CW-1:0]       cmp_rd;
   logic [RW-1:0]       bak_rd;
   logic [SAMPLE_W-1:0] dec_val, raw_val, next_val;

   assign cmp_en = r1_valid && (r1_tag == GT_HIT);
   assign bak_en = r1_valid && (r1_tag == GT_MISS);
   assign cmp_rd = cmp_en ? cmp_mem[r1_grp] : '0;
   assign bak_rd = bak_en ? bak_mem[r1_slot] : '0;

   bpd_lane_decode #(.SAMPLE_W(SAMPLE_W), .GROUP_N(GROUP_N)) u_dec (
      .entry(cmp_rd), .lane(r1_lane), .quarter(quarter_mode), .value(dec_val)
   );

   always_comb begin
      raw_val = '0;
      for (int k = 0; k < GROUP_N; k++)
         if (r1_lane == LANE_W'(k)) raw_val = bak_rd[k*SAMPLE_W +: SAMPLE_W];
   end

   assign next_val = cmp_en ? dec_val : (bak_en ? raw_val : '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= r1_valid;
         rd_data  <= next_val;
      end
   end

   // ---------------- assertions ----------------
   logic [1:0] warm_q;
   always_ff @(posedge clk) begin
      if (rst)                 warm_q <= '0;
      else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
   end

   p_fixed_latency_r5: assert property (@(posedge clk) disable iff (rst)
      (warm_q == 2'd2) |-> (rd_valid == $past(rd_req, 2)));

   p_hit_section_r2: assert property (@(posedge clk) disable iff (rst)
      cmp_en |-> (tag_q[r1_grp] == GT_HIT));

   p_backup_section_r4: assert property (@(posedge clk) disable iff (rst)
      bak_en |-> (tag_q[r1_grp] == GT_MISS));

   p_single_commit_r7: assert property (@(posedge clk) disable iff (rst)
      (warm_q != 2'd0) |-> !((hit_count != $past(hit_count)) &&
                             (miss_count != $past(miss_count))));

   p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow);

   p_drop_when_full_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(overflow) |-> (bak_ptr_q == PTR_W'(BACKUP_SLOTS)));

   p_full_blocks_r9: assert property (@(posedge clk) disable iff (rst)
      (({1'b0, hit_count} + {1'b0, miss_count}) == (CNT_W+1)'(GROUPS))
         |-> !in_ready);
endmodule

// File: tb/bpd_sample_store_test.sv
module bpd_sample_store_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic quarter_mode = 1'b0;
   logic in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic in_ready;
   logic rd_req = 1'b0;
   logic [5:0] rd_index = '0;
   logic rd_valid;
   logic [15:0] rd_data;
   logic overflow;
   logic [4:0] hit_count, miss_count;

   always #5 clk = ~clk;

   bpd_sample_store uut (
      .clk(clk), .rst(rst), .quarter_mode(quarter_mode),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .rd_req(rd_req), .rd_index(rd_index), .rd_valid(rd_valid),
      .rd_data(rd_data), .overflow(overflow),
      .hit_count(hit_count), .miss_count(miss_count)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // reference model
   logic signed [15:0] exp_mem [64];
   int m_grp, m_hit, m_miss, m_bak;
   bit m_ovf;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic do_reset(input bit q);
      rst = 1'b1; quarter_mode = q; in_valid = 1'b0; rd_req = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 64; i++) exp_mem[i] = '0;
      m_grp = 0; m_hit = 0; m_miss = 0; m_bak = 0; m_ovf = 0;
   endtask

   task automatic model_group(input int a, input int b, input int c, input int d);
      int lim;
      bit hit;
      lim = quarter_mode ? 8 : 128;
      hit = (b - a >= -lim) && (b - a < lim) && (c - a >= -lim) && (c - a < lim)
         && (d - a >= -lim) && (d - a < lim);
      if (hit || m_bak < 4) begin
         exp_mem[m_grp*4]   = 16'(a); exp_mem[m_grp*4+1] = 16'(b);
         exp_mem[m_grp*4+2] = 16'(c); exp_mem[m_grp*4+3] = 16'(d);
      end
      if (hit) m_hit++;
      else begin
         m_miss++;
         if (m_bak < 4) m_bak++; else m_ovf = 1;
      end
      m_grp++;
   endtask

   task automatic send_sample(input int v);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = 16'(v);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic push_group(input int a, input int b, input int c, input int d,
                             input bit settle);
      model_group(a, b, c, d);
      send_sample(a); send_sample(b); send_sample(c); send_sample(d);
      if (settle) begin
         repeat (2) @(negedge clk);
         check(hit_count == 5'(m_hit), "R7 hit_count", int'(hit_count), m_hit);
         check(miss_count == 5'(m_miss), "R7 miss_count", int'(miss_count), m_miss);
      end
   endtask

   task automatic read_check(input int idx, input int expv, input string req);
      @(negedge clk);
      rd_req = 1'b1; rd_index = 6'(idx);
      @(negedge clk);
      rd_req = 1'b0;
      check(rd_valid == 1'b0, "R5 early valid", int'(rd_valid), 0);
      @(negedge clk);
      check(rd_valid == 1'b1, "R5 valid", int'(rd_valid), 1);
      check(rd_data == 16'(expv), req, int'($signed(rd_data)), int'($signed(16'(expv))));
   endtask

   task automatic t_reset_state(input bit q);
      do_reset(q);
      @(negedge clk);
      check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
      check(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
      check(hit_count == 5'd0, "R1 hit_count", int'(hit_count), 0);
      check(miss_count == 5'd0, "R1 miss_count", int'(miss_count), 0);
      read_check(0, 0, "R1 read after reset");
   endtask

   task automatic t_half_commit_timing;
      push_group(1000, 1127, 872, 1003, 1'b0);
      read_check(0, 0, "R6 read on commit cycle");
      read_check(0, 1000, "R6 read after commit");
      read_check(1, 1127, "R2 delta +127");
      read_check(2, 872, "R2 delta -128");
      read_check(3, 1003, "R2 delta 3");
      check(hit_count == 5'd1, "R7 hit_count", int'(hit_count), 1);
   endtask

   task automatic t_half_backup;
      push_group(0, 128, 0, 0, 1'b1);
      read_check(5, 128, "R2 delta 128 misses");
      push_group(-32768, 32767, 0, 5, 1'b1);
      read_check(8, -32768, "R4 extreme low");
      read_check(9, 32767, "R4 extreme high");
      push_group(500, -500, 7, 9, 1'b1);
      push_group(1, 2, 300, 4, 1'b1);
      check(overflow == 1'b0, "R8 no overflow at capacity", int'(overflow), 0);
   endtask

   task automatic t_overflow;
      push_group(10, 20, -200, 30, 1'b1);
      check(overflow == 1'b1, "R8 overflow set", int'(overflow), 1);
      read_check(22, 0, "R8 dropped group reads 0");
      push_group(-100, -50, -150, 27, 1'b1);
      read_check(26, -150, "R8 hit after drop");
      check(overflow == 1'b1, "R8 overflow sticky", int'(overflow), 1);
   endtask

   task automatic t_fill_full;
      for (int g = 7; g < 16; g++)
         push_group(g*1000 - 8000, g*1000 - 8000 + g, g*1000 - 8000 - g,
                    g*1000 - 7998, 1'b1);
      @(negedge clk);
      check(in_ready == 1'b0, "R9 in_ready low when full", int'(in_ready), 0);
      in_valid = 1'b1; in_data = 16'h1234;
      repeat (4) @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(in_ready == 1'b0, "R9 still full", int'(in_ready), 0);
      check(hit_count == 5'd11, "R9 hit_count frozen", int'(hit_count), 11);
      check(miss_count == 5'd5, "R9 miss_count frozen", int'(miss_count), 5);
      for (int i = 0; i < 64; i++)
         read_check(i, int'(exp_mem[i]), "R2 R4 R8 sweep");
   endtask

   task automatic t_quarter;
      push_group(100, 107, 92, 100, 1'b1);
      check(hit_count == 5'd1, "R3 [-8,7] packed", int'(hit_count), 1);
      push_group(100, 108, 100, 100, 1'b1);
      check(miss_count == 5'd1, "R3 delta 8 misses", int'(miss_count), 1);
      push_group(-5, 2, -13, -5, 1'b1);
      // partial group stays invisible
      model_group(40, 41, 39, 33);
      send_sample(40); send_sample(41);
      repeat (2) @(negedge clk);
      read_check(12, 0, "R6 partial group");
      send_sample(39); send_sample(33);
      repeat (2) @(negedge clk);
      check(hit_count == 5'd3, "R7 quarter hits", int'(hit_count), 3);
      for (int i = 0; i < 16; i++)
         read_check(i, int'(exp_mem[i]), "R3 quarter sweep");
   endtask

   initial begin
      t_reset_state(1'b0);
      t_half_commit_timing();
      t_half_backup();
      t_overflow();
      t_fill_full();
      t_reset_state(1'b1);
      t_quarter();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule